// File: doc/BRIEF.md
# Full-Speed USB Receive Deframer

This block sits behind a full-speed clock and data recovery stage. Once per received bit it gets a strobe together with the sampled line state: J, K or single-ended zero. It undoes the NRZI line coding and hunts for the SYNC field that opens every packet. After SYNC it removes the stuffed zeros that the transmitter inserted, and it packs the surviving bits into bytes, least significant bit first. Each completed byte is handed to the protocol engine with a single-clock valid pulse, and a packet-active level frames the whole packet.

A packet ends normally with an end-of-packet marker: at least two bit times of single-ended zero, then J. A run of ones longer than the stuffing rule allows is a bit-stuff violation. It aborts the packet, raises the error output and drops the active level. The deframer then ignores the line until the next end-of-packet marker. Every output is registered in the parallel clock domain.

Top module: `usbrx_deframer`

## Requirements
- R1: Line states are encoded J = 2'b01, K = 2'b10 and single-ended zero = 2'b00; 2'b11 is handled like single-ended zero. A sample is taken only in a clock where `bit_en` is high. The decoded bit is 1 when the level equals the previous J/K level and 0 when it differs. The previous level counts as J after reset and after any single-ended sample.
- R2: While hunting, `rx_active` rises in the clock after the strobe that completes seven decoded 0s followed by a decoded 1 (line KJKJKJKK after idle J, the byte 0x80 sent LSB first).
- R3: Kept bits are packed LSB first. In the clock after the strobe that delivers the eighth kept bit of a byte, `rx_valid` is high for exactly one clock and `rx_data` holds that byte. `rx_valid` is never high while `rx_active` is low.
- R4: After six consecutive decoded 1s, where the final 1 of SYNC counts toward the run, the next decoded 0 is discarded and restarts the run.
- R5: A decoded 1 that follows six consecutive 1s is a stuff error. In the next clock `rx_error` is high for one clock and `rx_active` is low, and no further byte of that packet is delivered.
- R6: After a stuff error the line is ignored, including any SYNC pattern, until a single-ended zero strobe is followed by a J strobe.
- R7: Two or more single-ended zero strobes followed by a J strobe end the packet. `rx_active` is low in the clock after the J strobe and `rx_error` stays low. Bits of an unfinished byte are dropped without a `rx_valid` pulse.
- R8: A single-ended zero lasting fewer than two strobes, or one followed by K, ends the packet. `rx_error` pulses and `rx_active` falls in the clock after the strobe that ended the marker.
- R9: During and right after reset, `rx_active`, `rx_valid` and `rx_error` are low and `rx_data` is zero.
- R10: Constant idle J never raises `rx_active`. Line changes in clocks without `bit_en`, including single-ended glitches, do not alter the received bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-clock strobe marking a recovered bit |
| line_state | input | 2 | Sampled line: 01 J, 10 K, 00 single-ended zero |
| rx_data | output | DATA_W | Received byte, valid while rx_valid is high |
| rx_valid | output | 1 | One-clock pulse per completed byte |
| rx_active | output | 1 | High from SYNC recognition to end of packet or error |
| rx_error | output | 1 | One-clock pulse on stuff error or malformed end of packet |

## Verification
Every byte value 0 to 255 is sent in a packet next to its complement. This sweep covers runs of ones that need a stuffed zero, runs that end exactly at six, and byte boundaries that fall inside a stuffed run, so an off-by-one in the run counter or in the bit order shows up as a wrong byte. Raw streams with seven ones after SYNC check that a stuff violation aborts the packet and that a SYNC sent before the next end-of-packet stays ignored. Trailing partial bytes, one-bit single-ended zeros and a single-ended zero followed by K check that a packet ends cleanly only on a well-formed marker. A packet sent with single-ended glitches between strobes must decode the same as a clean one.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

   typedef enum logic [1:0] {
      LS_SE0 = 2'b00,
      LS_J   = 2'b01,
      LS_K   = 2'b10,
      LS_SE1 = 2'b11
   } line_t;

   typedef enum logic [1:0] {
      ST_HUNT  = 2'd0,
      ST_DATA  = 2'd1,
      ST_EOP   = 2'd2,
      ST_DRAIN = 2'd3
   } rx_state_t;

endpackage

// File: rtl/usbrx_nrzi.sv
module usbrx_nrzi
   import usbrx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  logic [1:0] line_state,
   output logic       dec_bit,
   output logic       dec_se,
   output logic       dec_j
);

   logic prev_j_q;

   // J and K are the only differential states; the other two codes are single-ended
   always_comb begin
      dec_se  = (line_state == LS_SE0) || (line_state == LS_SE1);
      dec_j   = (line_state == LS_J);
      dec_bit = (dec_j == prev_j_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_j_q <= 1'b1;
      end else if (bit_en) begin
         prev_j_q <= dec_se ? 1'b1 : dec_j;
      end
   end

endmodule

// File: rtl/usbrx_sync_det.sv
module usbrx_sync_det #(
   parameter int SYNC_LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic shift_en,
   input  logic din,
   output logic hit
);

   localparam logic [SYNC_LEN-1:0] SYNC_PAT = {1'b1, {(SYNC_LEN-1){1'b0}}};

   logic [SYNC_LEN-1:0] win_q;
   logic [SYNC_LEN-1:0] win_nxt;

   // newest bit enters at the top, so the first bit of the field ends up at bit 0
   assign win_nxt = {din, win_q[SYNC_LEN-1:1]};
   assign hit     = shift_en && (win_nxt == SYNC_PAT);

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         win_q <= '1;
      end else if (shift_en) begin
         win_q <= win_nxt;
      end
   end

endmodule

// File: rtl/usbrx_unstuff.sv
module usbrx_unstuff #(
   parameter int STUFF_RUN = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic in_en,
   input  logic din,
   output logic keep_en,
   output logic keep_bit,
   output logic stuff_err
);

   localparam int RUN_W = $clog2(STUFF_RUN + 1);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(STUFF_RUN);

   logic [RUN_W-1:0] ones_q;
   logic             at_limit;

   always_comb begin
      at_limit  = (ones_q == RUN_MAX);
      keep_en   = in_en && !at_limit;
      keep_bit  = din;
      stuff_err = in_en && at_limit && din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ones_q <= '0;
      end else if (restart) begin
         // the closing one of SYNC opens the run
         ones_q <= RUN_W'(1);
      end else if (in_en) begin
         if (at_limit || !din) begin
            ones_q <= '0;
         end else begin
            ones_q <= ones_q + RUN_W'(1);
         end
      end
   end

endmodule

// File: rtl/usbrx_shifter.sv
module usbrx_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              shift_en,
   input  logic              din,
   output logic              done,
   output logic [DATA_W-1:0] word
);

   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;

   always_comb begin
      word = {din, sh_q[DATA_W-1:1]};
      done = shift_en && (cnt_q == CNT_LAST);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (shift_en) begin
         sh_q  <= word;
         cnt_q <= done ? '0 : cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/usbrx_deframer.sv
module usbrx_deframer
   import usbrx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int STUFF_RUN = 6,
   parameter int SYNC_LEN  = 8,
   parameter int EOP_SE0   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic [1:0]        line_state,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_active,
   output logic              rx_error
);

   localparam int SE_W = $clog2(EOP_SE0 + 1);
   localparam logic [SE_W-1:0] SE_MIN = SE_W'(EOP_SE0);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("usbrx_deframer: DATA_W must be at least 2");
      end
      if (STUFF_RUN < 1) begin : g_bad_run
         $error("usbrx_deframer: STUFF_RUN must be at least 1");
      end
      if (SYNC_LEN < 2) begin : g_bad_sync
         $error("usbrx_deframer: SYNC_LEN must be at least 2");
      end
      if (EOP_SE0 < 1) begin : g_bad_eop
         $error("usbrx_deframer: EOP_SE0 must be at least 1");
      end
   endgenerate

   rx_state_t           state_q;
   logic [SE_W-1:0]     se_cnt_q;
   logic                dec_bit, dec_se, dec_j;
   logic                sync_shift, sync_flush, sync_hit;
   logic                us_in_en, keep_en, keep_bit, stuff_err;
   logic                byte_done;
   logic [DATA_W-1:0]   byte_word;
   logic                jk_strobe;

   usbrx_nrzi u_nrzi (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_en     (bit_en),
      .line_state (line_state),
      .dec_bit    (dec_bit),
      .dec_se     (dec_se),
      .dec_j      (dec_j)
   );

   always_comb begin
      jk_strobe  = bit_en && !dec_se;
      sync_shift = jk_strobe && (state_q == ST_HUNT);
      sync_flush = (state_q != ST_HUNT) || (bit_en && dec_se);
      us_in_en   = jk_strobe && (state_q == ST_DATA);
   end

   usbrx_sync_det #(.SYNC_LEN(SYNC_LEN)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (sync_flush),
      .shift_en (sync_shift),
      .din      (dec_bit),
      .hit      (sync_hit)
   );

   usbrx_unstuff #(.STUFF_RUN(STUFF_RUN)) u_unstuff (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (sync_hit),
      .in_en     (us_in_en),
      .din       (dec_bit),
      .keep_en   (keep_en),
      .keep_bit  (keep_bit),
      .stuff_err (stuff_err)
   );

   usbrx_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (sync_hit),
      .shift_en (keep_en),
      .din      (keep_bit),
      .done     (byte_done),
      .word     (byte_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_HUNT;
         se_cnt_q  <= '0;
         rx_active <= 1'b0;
         rx_error  <= 1'b0;
         rx_valid  <= 1'b0;
         rx_data   <= '0;
      end else begin
         rx_error <= 1'b0;
         rx_valid <= byte_done;
         if (byte_done) begin
            rx_data <= byte_word;
         end
         case (state_q)
            ST_HUNT: begin
               if (sync_hit) begin
                  state_q   <= ST_DATA;
                  rx_active <= 1'b1;
               end
            end
            ST_DATA: begin
               if (bit_en && dec_se) begin
                  state_q  <= ST_EOP;
                  se_cnt_q <= SE_W'(1);
               end else if (stuff_err) begin
                  state_q   <= ST_DRAIN;
                  se_cnt_q  <= '0;
                  rx_active <= 1'b0;
                  rx_error  <= 1'b1;
               end
            end
            ST_EOP: begin
               if (bit_en && dec_se) begin
                  if (se_cnt_q != SE_MIN) begin
                     se_cnt_q <= se_cnt_q + SE_W'(1);
                  end
               end else if (jk_strobe) begin
                  state_q   <= ST_HUNT;
                  se_cnt_q  <= '0;
                  rx_active <= 1'b0;
                  if ((se_cnt_q < SE_MIN) || !dec_j) begin
                     rx_error <= 1'b1;
                  end
               end
            end
            default: begin
               if (bit_en && dec_se) begin
                  se_cnt_q <= SE_W'(1);
               end else if (jk_strobe) begin
                  if ((se_cnt_q != '0) && dec_j) begin
                     state_q <= ST_HUNT;
                  end
                  se_cnt_q <= '0;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/usbrx_deframer_chk.sv
module usbrx_deframer_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic rx_valid,
   input logic rx_active,
   input logic rx_error
);

   AST_VALID_IN_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> rx_active); // R3

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid); // R3

   AST_ACTIVE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_active) |-> $past(bit_en)); // R2

   AST_ERR_DROPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_error |-> !rx_active); // R5

   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_error |=> !rx_error); // R5

   AST_END_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_active) |-> !rx_valid); // R7

   AST_ERR_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_error) |-> $past(bit_en)); // R8

endmodule

bind usbrx_deframer usbrx_deframer_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_en    (bit_en),
   .rx_valid  (rx_valid),
   .rx_active (rx_active),
   .rx_error  (rx_error)
);

// File: tb/tb_usbrx_deframer.sv
module tb_usbrx_deframer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic [1:0] line_state = 2'b01;
   logic [7:0] rx_data;
   logic       rx_valid, rx_active, rx_error;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] got[$];
   int  err_seen = 0;
   int  rises = 0;
   logic act_prev = 1'b0;

   bit  lvl_j = 1'b1;
   int  ones = 0;
   bit  glitch = 1'b0;

   always #2 clk = ~clk;

   usbrx_deframer dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_en     (bit_en),
      .line_state (line_state),
      .rx_data    (rx_data),
      .rx_valid   (rx_valid),
      .rx_active  (rx_active),
      .rx_error   (rx_error)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_valid) got.push_back(rx_data);
         if (rx_error) err_seen++;
         if (rx_active && !act_prev) rises++;
         act_prev = rx_active;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] ls);
      @(negedge clk);
      line_state = ls;
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      if (glitch) line_state = 2'b00;
      @(negedge clk);
      if (glitch) line_state = (ls == 2'b01) ? 2'b10 : 2'b01;
      @(negedge clk);
      line_state = ls;
   endtask

   task automatic raw(input bit d);
      if (!d) lvl_j = !lvl_j;
      drive(lvl_j ? 2'b01 : 2'b10);
   endtask

   task automatic dbit(input bit d);
      raw(d);
      if (d) ones++; else ones = 0;
      if (ones == 6) begin
         raw(1'b0);
         ones = 0;
      end
   endtask

   task automatic idle(input int n);
      lvl_j = 1'b1;
      for (int i = 0; i < n; i++) drive(2'b01);
   endtask

   task automatic sync_field();
      for (int i = 0; i < 7; i++) raw(1'b0);
      raw(1'b1);
      ones = 1;
   endtask

   task automatic data_bits(input logic [7:0] b, input int n);
      for (int i = 0; i < n; i++) dbit(b[i]);
   endtask

   task automatic eop(input int se_n);
      for (int i = 0; i < se_n; i++) drive(2'b00);
      lvl_j = 1'b1;
      drive(2'b01);
   endtask

   task automatic clear_obs();
      got.delete();
      err_seen = 0;
      rises = 0;
   endtask

   initial begin
      logic [7:0] pk[4];
      bit ok;
      repeat (4) @(negedge clk);
      check(rx_active == 0 && rx_valid == 0 && rx_error == 0 && rx_data == 0,
            "R9 outputs in reset", {rx_active, rx_valid, rx_error}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(rx_active == 0 && rx_valid == 0 && rx_error == 0 && rx_data == 0,
            "R9 outputs after reset", {rx_active, rx_valid, rx_error}, 0);

      // R10 idle only
      clear_obs();
      idle(40);
      check(rises == 0, "R10 idle J keeps rx_active low", rises, 0);

      // R2 / R3 / R4 / R7 mixed packet
      pk[0] = 8'h00; pk[1] = 8'hFF; pk[2] = 8'hA5; pk[3] = 8'h3C;
      clear_obs();
      idle(4);
      sync_field();
      check(rx_active == 1, "R2 rx_active after SYNC", rx_active, 1);
      for (int i = 0; i < 4; i++) data_bits(pk[i], 8);
      eop(2);
      check(rx_active == 0, "R7 rx_active low after EOP", rx_active, 0);
      check(err_seen == 0, "R7 no error on clean EOP", err_seen, 0);
      check(got.size() == 4, "R3 byte count", got.size(), 4);
      ok = (got.size() == 4);
      for (int i = 0; i < 4 && ok; i++) ok = (got[i] == pk[i]);
      check(ok, "R4 bytes with stuffed run", (got.size() > 1) ? got[1] : -1, pk[1]);

      // R3 / R4 sweep: every value next to its complement
      for (int v = 0; v < 256; v++) begin
         clear_obs();
         idle(3);
         sync_field();
         data_bits(8'(v), 8);
         data_bits(~8'(v), 8);
         eop(2);
         ok = (got.size() == 2) && (got[0] == 8'(v)) && (got[1] == ~8'(v))
              && (err_seen == 0) && (rises == 1);
         check(ok, "R3 R4 sweep byte", (got.size() > 0) ? got[0] : -1, v);
      end

      // R7 partial byte dropped
      clear_obs();
      idle(3);
      sync_field();
      data_bits(8'hAB, 8);
      data_bits(8'h05, 3);
      eop(2);
      check(got.size() == 1 && got[0] == 8'hAB, "R7 partial byte dropped", got.size(), 1);
      check(err_seen == 0 && rx_active == 0, "R7 clean end after partial", err_seen, 0);

      // R5 stuff error
      clear_obs();
      idle(3);
      sync_field();
      for (int i = 0; i < 7; i++) raw(1'b1);
      check(err_seen == 1, "R5 stuff error pulse", err_seen, 1);
      check(rx_active == 0 && got.size() == 0, "R5 packet aborted", got.size(), 0);

      // R6 SYNC ignored before EOP
      clear_obs();
      raw(1'b0);
      sync_field();
      data_bits(8'h12, 8);
      check(rises == 0 && got.size() == 0, "R6 SYNC ignored after error", rises, 0);
      eop(2);
      idle(2);
      sync_field();
      data_bits(8'h5A, 8);
      eop(2);
      check(rises == 1 && got.size() == 1 && got[0] == 8'h5A,
            "R6 recovery after EOP", (got.size() > 0) ? got[0] : -1, 8'h5A);

      // R8 short single-ended zero
      clear_obs();
      idle(3);
      sync_field();
      data_bits(8'h55, 8);
      eop(1);
      check(err_seen == 1 && rx_active == 0, "R8 one-bit SE0 flagged", err_seen, 1);
      check(got.size() == 1 && got[0] == 8'h55, "R8 byte before short EOP", got.size(), 1);

      // R8 SE0 then K
      clear_obs();
      idle(3);
      sync_field();
      data_bits(8'hC3, 8);
      drive(2'b00);
      drive(2'b00);
      drive(2'b10);
      check(err_seen == 1 && rx_active == 0, "R8 SE0 then K flagged", err_seen, 1);
      idle(4);

      // R1 / R10 glitches between strobes
      clear_obs();
      glitch = 1'b1;
      idle(3);
      sync_field();
      data_bits(8'h96, 8);
      data_bits(8'h7F, 8);
      eop(2);
      glitch = 1'b0;
      check(got.size() == 2 && got[0] == 8'h96 && got[1] == 8'h7F,
            "R1 R10 glitches ignored", (got.size() > 0) ? got[0] : -1, 8'h96);

      // R1 SE1 treated as single-ended
      clear_obs();
      idle(3);
      sync_field();
      data_bits(8'h81, 8);
      drive(2'b11);
      drive(2'b11);
      lvl_j = 1'b1;
      drive(2'b01);
      check(got.size() == 1 && err_seen == 0 && rx_active == 0,
            "R1 SE1 ends packet like SE0", err_seen, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule